// File: doc/BRIEF.md
# Capture Buffer Bus Readout

This block puts a sample-capture engine on a 32-bit pipelined Wishbone slave with one address bit. Address 0 is a command/status word. A write to it loads the post-trigger hold count and the force-trigger and auto-trigger-mask commands. The same write can also order the engine to restart. A read of it returns the engine's state flags, the buffer size and the hold count. Address 1 is the sample port. Before the engine has stopped, this port shows the live 32-bit probe input. After the engine stops, it plays back the capture buffer, starting with the oldest sample.

The word is arranged so that software can restart a capture by writing only the hold count: bit 31 then reads as zero, and a zero in bit 31 commands a restart. Playback uses a read offset that is added to the engine's write pointer, modulo the buffer length. The offset steps on every sample-port read once the engine has stopped. A write to the sample port stores nothing; it only sets the offset back to the oldest sample. The block shares the engine's clock. The engine reads its buffer asynchronously at the address this block drives.

Top module: `scope_readout`

## Requirements
- R1: A command write (address 0) with bit 31 = 0 raises `capReset` for exactly one cycle, the cycle after the write is strobed. `capHoldoff` takes data bits 19:0, `capManual` takes bit 27 and `capDisable` takes bit 26.
- R2: A command write with bit 31 = 1 updates `capHoldoff`, `capManual` and `capDisable` in the same way, but does not raise `capReset`.
- R3: A command read strobed in the cycle right after a restart command returns bit 31 = 1. Once the restart pulse has passed, bit 31 reads 0.
- R4: A command read returns this word: bit 31 restart pending, bit 30 `engStopped`, bit 29 `engTriggered`, bit 28 `engPrimed`, bit 27 force-trigger, bit 26 mask, bit 25 offset-at-zero, bits 24:20 LGMEM, bits 19:0 hold count.
- R5: While `engStopped` = 0, a sample-port read returns `liveData` and leaves the read offset unchanged.
- R6: While `engStopped` = 1, a sample-port read returns the buffer word at (`engWrPtr` + offset) mod 2^LGMEM and then advances the offset by one. 2^LGMEM reads return the whole buffer from oldest to newest, and the next read wraps back to the oldest sample.
- R7: A write to the sample port (address 1) sets the offset to zero and changes neither the hold count nor the commands.
- R8: Bit 25 of the command word is 1 exactly when the offset is zero, that is, when the next stopped read will return the oldest sample.
- R9: `wbAck` is high in the cycle after each strobed access, but only while `wbCyc` is still high. `wbStall` is always 0, so back-to-back reads are taken one per clock.
- R10: A restart command also sets the read offset to zero.
- R11: After `rstN` is released, `wbAck`, `capReset`, `capManual`, `capDisable` and `capHoldoff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and engine clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Access strobe |
| wbWe | input | 1 | Write when high |
| wbAddr | input | 1 | 0 = command/status, 1 = sample port |
| wbWrData | input | 32 | Write data |
| wbAck | output | 1 | Access acknowledge |
| wbStall | output | 1 | Always 0 |
| wbRdData | output | 32 | Registered read data |
| liveData | input | 32 | Live probe word |
| engStopped | input | 1 | Engine has stopped capturing |
| engTriggered | input | 1 | Engine has seen its trigger |
| engPrimed | input | 1 | Engine buffer is full |
| engWrPtr | input | LGMEM | Engine next-write (oldest) index |
| memAddr | output | LGMEM | Buffer read address |
| memRdData | input | 32 | Buffer word at `memAddr` |
| capReset | output | 1 | One-cycle restart pulse |
| capManual | output | 1 | Force-trigger command |
| capDisable | output | 1 | Auto-trigger mask |
| capHoldoff | output | 20 | Post-trigger hold count |

## Verification
All results appear at the ports one register after the strobed edge. The acknowledge and the read word are both due in the cycle that follows the strobe. The restart pulse and any updated command outputs are due in that same cycle. A pending-restart flag can be seen only by a read strobed in the very next cycle. The bench drives inputs on falling edges and samples on the following falling edge, exactly one rising edge later. To catch the pending flag, it keeps the strobe high for a second, pipelined access. Pointer effects are checked through the next access: an offset-at-zero bit in the command word, or the value the following sample-port read returns.

// File: rtl/scope_readout_pkg.sv
package scope_readout_pkg;

  // Strobes from the bus decoder to the register datapath.
  typedef struct packed {
    logic ctrlWr;
    logic ctrlRd;
    logic dataWr;
    logic dataRd;
  } scopeStrobeT;

  localparam int HOLD_W     = 20;
  localparam int BIT_NRST   = 31;
  localparam int BIT_MANUAL = 27;
  localparam int BIT_MASK   = 26;

endpackage

// File: rtl/scope_bus_ctrl.sv
module scope_bus_ctrl
  import scope_readout_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbCyc,
  input  logic        wbStb,
  input  logic        wbWe,
  input  logic        wbAddr,
  output logic        wbAck,
  output logic        wbStall,
  output scopeStrobeT strobes
);

  logic access;
  logic ackQ;

  assign access = wbCyc & wbStb;

  always_comb begin
    strobes.ctrlWr = access &  wbWe & ~wbAddr;
    strobes.ctrlRd = access & ~wbWe & ~wbAddr;
    strobes.dataWr = access &  wbWe &  wbAddr;
    strobes.dataRd = access & ~wbWe &  wbAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= access;
  end

  // An acknowledge is dropped if the master abandoned the cycle.
  assign wbAck   = ackQ & wbCyc;
  assign wbStall = 1'b0;

  assert_ack_after_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbStb) |=> (wbAck || !wbCyc));
  assert_ack_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |-> $past(wbCyc && wbStb));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/scope_reg_datapath.sv
module scope_reg_datapath
  import scope_readout_pkg::*;
#(
  parameter int LGMEM = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  scopeStrobeT       strobes,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       liveData,
  input  logic              engStopped,
  input  logic              engTriggered,
  input  logic              engPrimed,
  input  logic [LGMEM-1:0]  engWrPtr,
  output logic [LGMEM-1:0]  memAddr,
  input  logic [31:0]       memRdData,
  output logic              capReset,
  output logic              capManual,
  output logic              capDisable,
  output logic [HOLD_W-1:0] capHoldoff
);

  typedef logic [LGMEM-1:0] ptrT;
  localparam logic [4:0] LG_FIELD = 5'(LGMEM);

  ptrT         rdPtr;
  logic        pendReset;
  logic        ptrAtZero;
  logic        restartCmd;
  logic [31:0] statusWord;

  assign restartCmd = strobes.ctrlWr & ~wrData[BIT_NRST];
  assign ptrAtZero  = (rdPtr == '0);
  assign memAddr    = engWrPtr + rdPtr;   // wraps modulo 2^LGMEM
  assign capReset   = pendReset;

  assign statusWord = {pendReset, engStopped, engTriggered, engPrimed,
                       capManual, capDisable, ptrAtZero, LG_FIELD, capHoldoff};

  // Command fields.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capHoldoff <= '0;
      capManual  <= 1'b0;
      capDisable <= 1'b0;
      pendReset  <= 1'b0;
    end else begin
      pendReset <= restartCmd;
      if (strobes.ctrlWr) begin
        capHoldoff <= wrData[HOLD_W-1:0];
        capManual  <= wrData[BIT_MANUAL];
        capDisable <= wrData[BIT_MASK];
      end
    end
  end

  // Playback offset.
  always_ff @(posedge clk) begin
    if (!rstN)                          rdPtr <= '0;
    else if (restartCmd || strobes.dataWr) rdPtr <= '0;
    else if (strobes.dataRd && engStopped) rdPtr <= rdPtr + 1'b1;
  end

  // Read data, valid together with the acknowledge.
  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobes.ctrlRd) rdData <= statusWord;
    else if (strobes.dataRd) rdData <= engStopped ? memRdData : liveData;
  end

  assert_reset_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    capReset |=> !capReset);
  assert_reset_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rstN)
    restartCmd |=> capReset);
  assert_no_reset_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ctrlWr && wrData[BIT_NRST]) |=> !capReset);
  assert_live_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataRd && !engStopped) |=> $stable(rdPtr));
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataRd && engStopped) |=> (rdPtr == ptrT'($past(rdPtr) + 1'b1)));
  assert_data_wr_rewind_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataWr |=> (rdPtr == '0));
  assert_restart_rewind_R10: assert property (@(posedge clk) disable iff (!rstN)
    restartCmd |=> (rdPtr == '0));

endmodule

// File: rtl/scope_readout.sv
module scope_readout
  import scope_readout_pkg::*;
#(
  parameter int LGMEM = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic              wbAddr,
  input  logic [31:0]       wbWrData,
  output logic              wbAck,
  output logic              wbStall,
  output logic [31:0]       wbRdData,
  input  logic [31:0]       liveData,
  input  logic              engStopped,
  input  logic              engTriggered,
  input  logic              engPrimed,
  input  logic [LGMEM-1:0]  engWrPtr,
  output logic [LGMEM-1:0]  memAddr,
  input  logic [31:0]       memRdData,
  output logic              capReset,
  output logic              capManual,
  output logic              capDisable,
  output logic [HOLD_W-1:0] capHoldoff
);

  scopeStrobeT strobes;

  scope_bus_ctrl u_bus (
    .clk     (clk),
    .rstN    (rstN),
    .wbCyc   (wbCyc),
    .wbStb   (wbStb),
    .wbWe    (wbWe),
    .wbAddr  (wbAddr),
    .wbAck   (wbAck),
    .wbStall (wbStall),
    .strobes (strobes)
  );

  scope_reg_datapath #(.LGMEM(LGMEM)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrData       (wbWrData),
    .rdData       (wbRdData),
    .liveData     (liveData),
    .engStopped   (engStopped),
    .engTriggered (engTriggered),
    .engPrimed    (engPrimed),
    .engWrPtr     (engWrPtr),
    .memAddr      (memAddr),
    .memRdData    (memRdData),
    .capReset     (capReset),
    .capManual    (capManual),
    .capDisable   (capDisable),
    .capHoldoff   (capHoldoff)
  );

endmodule

// File: tb/scope_readout_tb.sv
`timescale 1ns/1ps
module scope_readout_tb;

  localparam int LGMEM = 5;
  localparam int DEPTH = 1 << LGMEM;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wbCyc = 0, wbStb = 0, wbWe = 0, wbAddr = 0;
  logic [31:0] wbWrData = '0;
  logic wbAck, wbStall;
  logic [31:0] wbRdData;
  logic [31:0] liveData = '0;
  logic engStopped = 0, engTriggered = 0, engPrimed = 0;
  logic [LGMEM-1:0] engWrPtr = '0;
  logic [LGMEM-1:0] memAddr;
  logic [31:0] memRdData;
  logic capReset, capManual, capDisable;
  logic [19:0] capHoldoff;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  // Buffer model: contents are computed, read asynchronously.
  function automatic logic [31:0] memWord(int idx);
    return 32'hA500_0000 + 32'(idx * 3);
  endfunction
  assign memRdData = memWord(int'(memAddr));

  scope_readout #(.LGMEM(LGMEM)) u_dut (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAddr(wbAddr), .wbWrData(wbWrData), .wbAck(wbAck), .wbStall(wbStall),
    .wbRdData(wbRdData), .liveData(liveData), .engStopped(engStopped),
    .engTriggered(engTriggered), .engPrimed(engPrimed), .engWrPtr(engWrPtr),
    .memAddr(memAddr), .memRdData(memRdData), .capReset(capReset),
    .capManual(capManual), .capDisable(capDisable), .capHoldoff(capHoldoff)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access; returns ack and read word sampled one edge later.
  task automatic busXfer(input logic we, input logic adr, input logic [31:0] wd,
                         output logic [31:0] rd, output logic ack);
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = we; wbAddr = adr; wbWrData = wd;
    @(negedge clk);
    wbStb = 0;
    ack = wbAck;
    rd = wbRdData;
    wbCyc = 0; wbWe = 0;
  endtask

  function automatic logic [31:0] statusExp(logic pend, logic [19:0] hold,
                                            logic man, logic msk, logic z);
    return {pend, engStopped, engTriggered, engPrimed, man, msk, z, 5'(LGMEM), hold};
  endfunction

  // Command-write table: {write word, expected restart pulse}
  localparam int NVEC = 5;
  localparam logic [32:0] CMD_VEC [NVEC] = '{
    {32'h0000_0010, 1'b1},
    {32'h8C00_0123, 1'b0},
    {32'h0400_00FF, 1'b1},
    {32'h8800_ABCD, 1'b0},
    {32'h8000_0005, 1'b0}
  };

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic ack;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 ack", 32'(wbAck), 0);
    check("R11 capReset", 32'(capReset), 0);
    check("R11 commands", {30'd0, capManual, capDisable}, 0);
    check("R11 holdoff", 32'(capHoldoff), 0);
    check("R9 stall", 32'(wbStall), 0);

    // R1/R2 table walk
    for (int i = 0; i < NVEC; i++) begin
      busXfer(1'b1, 1'b0, CMD_VEC[i][32:1], rd, ack);
      check("R9 write ack", 32'(ack), 1);
      check(CMD_VEC[i][0] ? "R1 restart pulse" : "R2 no restart", 32'(capReset), 32'(CMD_VEC[i][0]));
      check("R1 R2 holdoff", 32'(capHoldoff), 32'(CMD_VEC[i][20:1]));
      check("R1 R2 manual", 32'(capManual), 32'(CMD_VEC[i][28]));
      check("R1 R2 mask", 32'(capDisable), 32'(CMD_VEC[i][27]));
      @(negedge clk);
      check("R1 pulse one cycle", 32'(capReset), 0);
    end

    // R3: restart then pipelined status read
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAddr = 0; wbWrData = 32'h0000_0040;
    @(negedge clk);
    wbWe = 0;
    @(negedge clk);
    wbStb = 0;
    check("R3 pending bit", wbRdData, statusExp(1'b1, 20'h40, 0, 0, 1));
    wbCyc = 0;
    busXfer(1'b0, 1'b0, 0, rd, ack);
    check("R3 pending clear", rd, statusExp(1'b0, 20'h40, 0, 0, 1));

    // R4 status layout with flags set
    busXfer(1'b1, 1'b0, 32'h8C00_0777, rd, ack);
    engPrimed = 1; engTriggered = 1;
    busXfer(1'b0, 1'b0, 0, rd, ack);
    check("R4 status word", rd, {4'b0011, 3'b111, 5'd5, 20'h00777});

    // R5 live read, pointer stays
    liveData = 32'hDEAD_BEEF;
    busXfer(1'b0, 1'b1, 0, rd, ack);
    check("R5 live data", rd, 32'hDEAD_BEEF);
    busXfer(1'b0, 1'b0, 0, rd, ack);
    check("R5 R8 offset unmoved", 32'(rd[25]), 1);

    // R6 full pipelined playback
    engStopped = 1; engWrPtr = 5'd7;
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAddr = 1;
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      if (k == DEPTH - 1) wbStb = 0;
      check("R6 R9 burst ack", 32'(wbAck), 1);
      check("R6 playback", wbRdData, memWord((7 + k) % DEPTH));
    end
    wbCyc = 0;
    busXfer(1'b0, 1'b0, 0, rd, ack);
    check("R8 zero after full pass", 32'(rd[25]), 1);
    busXfer(1'b0, 1'b1, 0, rd, ack);
    check("R6 wrap to oldest", rd, memWord(7));
    busXfer(1'b0, 1'b0, 0, rd, ack);
    check("R8 nonzero offset", 32'(rd[25]), 0);

    // R7 data write rewinds only
    busXfer(1'b0, 1'b1, 0, rd, ack);
    busXfer(1'b1, 1'b1, 32'hFFFF_FFFF, rd, ack);
    check("R7 commands kept", {capManual, capDisable, 10'd0, capHoldoff}, {2'b11, 10'd0, 20'h00777});
    check("R7 no restart", 32'(capReset), 0);
    busXfer(1'b0, 1'b1, 0, rd, ack);
    check("R7 rewound read", rd, memWord(7));

    // R10 restart rewinds
    busXfer(1'b0, 1'b1, 0, rd, ack);
    busXfer(1'b1, 1'b0, 32'h0000_0003, rd, ack);
    busXfer(1'b0, 1'b1, 0, rd, ack);
    check("R10 restart rewinds", rd, memWord(7));

    // R9 abandoned cycle gets no ack
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAddr = 0;
    @(negedge clk);
    wbStb = 0; wbCyc = 0;
    #1;
    check("R9 no ack without cyc", 32'(wbAck), 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule